// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the status side of a NOR-style flash model. It follows the life of an embedded program or erase operation and reports it in two ways. The first is an open-drain ready/busy line: the block drives it low while an operation runs and releases it otherwise, so the board needs a pull-up. The second is the status byte returned on reads: while an operation runs, each read returns a byte whose bit 6 is the inverse of what the previous busy read returned. The command decoder upstream delivers one-cycle strobes for program, erase, erase-suspend and resume, together with a flag saying that the target is protected. An external countdown timer reports completion of a real operation with a one-cycle done pulse.

A command aimed only at protected sectors starts no real operation. The block still reports busy and toggles for a fixed short window, about 1 us for a program and about 100 us for an erase, timed by an internal down-counter whose loads come from the clock frequency parameter. During erase suspend, the line is released, reads return array data and the toggle bit keeps its value. A program may be issued while erase is suspended; it toggles until done and then returns to the suspended state.

Reads use a plain strobe. The read port has no back-pressure: each read strobe is always accepted, and its result appears one cycle later with a one-cycle valid flag. The block does not decode addresses, so a read to any address behaves the same.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the mode is idle, `busy_oe_o` is 0 (line released), `rd_valid_o` is 0, and the held toggle bit is 0, so the first read made while busy returns bit 6 = 1.
- R2: An unprotected program strobe in idle makes `busy_oe_o` 1 from the clock edge that captures it. The line stays busy until the edge that captures `op_done_i`, after which it is released.
- R3: An unprotected erase strobe in idle makes `busy_oe_o` 1 until `op_done_i` is captured, and is then released. When program and erase strobes arrive together in idle, program wins.
- R4: A read strobe `rd_i` is always accepted. `rd_data_o` and a one-cycle `rd_valid_o` appear at the next clock edge.
- R5: A read captured while busy returns a byte whose only possibly-set bit is bit 6. That bit is the inverse of the value returned by the previous busy read.
- R6: A read captured while not busy returns `array_data_i` as sampled in the read cycle.
- R7: `cmd_susp_i` during erase releases the line, reads return array data, and bit 6 holds its value. `cmd_resume_i` then restores busy erase, and the next read returns the inverse of the held bit.
- R8: An unprotected program strobe while erase is suspended drives busy, and reads toggle. `op_done_i` returns the block to the suspended state (released, array reads), not to idle.
- R9: A protected program strobe holds busy for exactly PROG_WIN = CLK_MHZ*PROG_PROT_NS/1000 cycles with reads toggling, and `op_done_i` is ignored. The block then returns to idle, or to erase suspend if the strobe was issued there.
- R10: A protected erase strobe in idle holds busy for exactly ERASE_WIN = CLK_MHZ*ERASE_PROT_NS/1000 cycles, and then returns to idle.
- R11: Commands that do not apply are ignored. During a program, erase, suspend, resume and further program strobes leave it busy. In idle, `op_done_i` and `cmd_resume_i` leave the line released.
- R12: If `op_done_i` and `cmd_susp_i` arrive in the same cycle during erase, completion wins and the block goes to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_prog_i | input | 1 | Program command accepted (one-cycle strobe) |
| cmd_erase_i | input | 1 | Erase command accepted (one-cycle strobe) |
| cmd_susp_i | input | 1 | Erase-suspend command accepted |
| cmd_resume_i | input | 1 | Erase-resume command accepted |
| tgt_prot_i | input | 1 | Target of the program/erase strobe is protected |
| op_done_i | input | 1 | Real operation finished (pulse from the operation timer) |
| rd_i | input | 1 | Read strobe, any address |
| array_data_i | input | DW | Array data for non-busy reads |
| rd_data_o | output | DW | Read result, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read result valid, one cycle after rd_i |
| busy_oe_o | output | 1 | Open-drain enable: 1 pulls ready/busy low |

## Verification
The hardest state to reach is a protected program issued during erase suspend. Getting there takes an erase, a suspend, and then a protected program strobe. The window must then expire into the suspended state rather than idle, and the held toggle bit must stay unchanged through it and come back inverted after resume. The bench builds this path step by step and tracks the expected toggle value as one running bit across every busy read of the whole run. It also sweeps the number of reads per operation and counts the protected windows cycle by cycle against the lengths computed from the parameters.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    FS_IDLE   = 3'd0,
    FS_PROG   = 3'd1,
    FS_ERASE  = 3'd2,
    FS_ESUSP  = 3'd3,
    FS_ESPROG = 3'd4,
    FS_PROT   = 3'd5
  } fs_mode_e;

  function automatic logic mode_is_busy(input fs_mode_e m);
    return (m == FS_PROG) || (m == FS_ERASE) || (m == FS_ESPROG) || (m == FS_PROT);
  endfunction

  function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
    return (mhz * ns) / 1000;
  endfunction

endpackage

// File: rtl/fsg_win_timer.sv
module fsg_win_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expire_o,
  output logic          active_o
);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expire_o = act_q && (cnt_q == '0);
  assign active_o = act_q;

  AST_WIN_STOPS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q == '0 && !load_i) |=> !act_q) else $error("window overran"); // R9
  AST_WIN_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0 && !load_i) |=> (act_q && cnt_q == $past(cnt_q) - CW'(1)))
    else $error("window skipped"); // R10

endmodule

// File: rtl/fsg_mode_fsm.sv
module fsg_mode_fsm
  import fsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_prog_i,
  input  logic     cmd_erase_i,
  input  logic     cmd_susp_i,
  input  logic     cmd_resume_i,
  input  logic     tgt_prot_i,
  input  logic     op_done_i,
  input  logic     win_expire_i,
  output fs_mode_e mode_o,
  output logic     win_load_o,
  output logic     win_erase_o,
  output logic     busy_o
);

  fs_mode_e mode_q, mode_d;
  logic     ret_susp_q, ret_susp_d;

  always_comb begin
    mode_d      = mode_q;
    ret_susp_d  = ret_susp_q;
    win_load_o  = 1'b0;
    win_erase_o = 1'b0;
    unique case (mode_q)
      FS_IDLE: begin
        if (cmd_prog_i) begin
          if (tgt_prot_i) begin
            mode_d     = FS_PROT;
            win_load_o = 1'b1;
            ret_susp_d = 1'b0;
          end else begin
            mode_d = FS_PROG;
          end
        end else if (cmd_erase_i) begin
          if (tgt_prot_i) begin
            mode_d      = FS_PROT;
            win_load_o  = 1'b1;
            win_erase_o = 1'b1;
            ret_susp_d  = 1'b0;
          end else begin
            mode_d = FS_ERASE;
          end
        end
      end
      FS_PROG: begin
        if (op_done_i) mode_d = FS_IDLE;
      end
      FS_ERASE: begin
        if (op_done_i)       mode_d = FS_IDLE;
        else if (cmd_susp_i) mode_d = FS_ESUSP;
      end
      FS_ESUSP: begin
        if (cmd_resume_i) begin
          mode_d = FS_ERASE;
        end else if (cmd_prog_i) begin
          if (tgt_prot_i) begin
            mode_d     = FS_PROT;
            win_load_o = 1'b1;
            ret_susp_d = 1'b1;
          end else begin
            mode_d = FS_ESPROG;
          end
        end
      end
      FS_ESPROG: begin
        if (op_done_i) mode_d = FS_ESUSP;
      end
      FS_PROT: begin
        if (win_expire_i) mode_d = ret_susp_q ? FS_ESUSP : FS_IDLE;
      end
      default: mode_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= FS_IDLE;
      ret_susp_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      ret_susp_q <= ret_susp_d;
    end
  end

  assign mode_o = mode_q;
  assign busy_o = mode_is_busy(mode_q);

  AST_PROG_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FS_PROG && op_done_i) |=> (mode_q == FS_IDLE)) else $error("program end"); // R2
  AST_PROG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FS_PROG && !op_done_i) |=> (mode_q == FS_PROG)) else $error("program left"); // R11
  AST_SUSP_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FS_ERASE && cmd_susp_i && !op_done_i) |=> (mode_q == FS_ESUSP)) else $error("suspend"); // R7
  AST_DONE_BEATS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FS_ERASE && op_done_i) |=> (mode_q == FS_IDLE)) else $error("priority"); // R12
  AST_ESPROG_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FS_ESPROG && op_done_i) |=> (mode_q == FS_ESUSP)) else $error("esprog return"); // R8
  AST_PROT_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FS_PROT && !win_expire_i) |=> (mode_q == FS_PROT)) else $error("window cut"); // R9

endmodule

// File: rtl/fsg_read_path.sv
module fsg_read_path #(
  parameter int DW      = 8,
  parameter int TGL_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic          busy_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);

  logic          tgl_q;
  logic [DW-1:0] data_q;
  logic          vld_q;
  logic [DW-1:0] tgl_word;

  always_comb begin
    tgl_word          = '0;
    tgl_word[TGL_BIT] = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q  <= 1'b0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= rd_i;
      if (rd_i) begin
        if (busy_i) begin
          tgl_q  <= ~tgl_q;
          data_q <= tgl_word;
        end else begin
          data_q <= array_data_i;
        end
      end
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = vld_q;

  AST_BUSY_READ_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_i) |=> (tgl_q != $past(tgl_q))) else $error("no flip"); // R5
  AST_IDLE_HOLDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i) |=> $stable(tgl_q)) else $error("bit moved"); // R7
  AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_valid_o) else $error("valid missing"); // R4
  AST_VALID_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !rd_valid_o) else $error("stray valid"); // R4

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int CLK_MHZ       = 250,
  parameter int PROG_PROT_NS  = 1000,
  parameter int ERASE_PROT_NS = 100000,
  parameter int DW            = 8,
  parameter int TGL_BIT       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_prog_i,
  input  logic          cmd_erase_i,
  input  logic          cmd_susp_i,
  input  logic          cmd_resume_i,
  input  logic          tgt_prot_i,
  input  logic          op_done_i,
  input  logic          rd_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          busy_oe_o
);

  // Window lengths in cycles; both must come out at least 1.
  localparam int PROG_WIN  = ns_to_cycles(CLK_MHZ, PROG_PROT_NS);
  localparam int ERASE_WIN = ns_to_cycles(CLK_MHZ, ERASE_PROT_NS);
  localparam int WIN_MAX   = (PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN;
  localparam int CW        = (WIN_MAX < 2) ? 1 : $clog2(WIN_MAX);
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_WIN - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_WIN - 1);

  fs_mode_e      mode;
  logic          win_load, win_erase, win_expire, win_active, busy;
  logic [CW-1:0] win_val;

  assign win_val = win_erase ? ERASE_LOAD : PROG_LOAD;

  fsg_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_prog_i   (cmd_prog_i),
    .cmd_erase_i  (cmd_erase_i),
    .cmd_susp_i   (cmd_susp_i),
    .cmd_resume_i (cmd_resume_i),
    .tgt_prot_i   (tgt_prot_i),
    .op_done_i    (op_done_i),
    .win_expire_i (win_expire),
    .mode_o       (mode),
    .win_load_o   (win_load),
    .win_erase_o  (win_erase),
    .busy_o       (busy)
  );

  fsg_win_timer #(.CW(CW)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (win_load),
    .load_val_i (win_val),
    .expire_o   (win_expire),
    .active_o   (win_active)
  );

  fsg_read_path #(.DW(DW), .TGL_BIT(TGL_BIT)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_i         (rd_i),
    .busy_i       (busy),
    .array_data_i (array_data_i),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o)
  );

  assign busy_oe_o = busy;

  AST_PROT_HAS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FS_PROT) |-> win_active) else $error("window idle in protected mode"); // R9
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FS_IDLE && !cmd_prog_i && !cmd_erase_i) |=> !busy_oe_o) else $error("idle woke"); // R11

endmodule

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;

  localparam int CLK_MHZ = 4;
  localparam int PNS     = 1000;
  localparam int ENS     = 3000;
  localparam int PW      = CLK_MHZ * PNS / 1000;
  localparam int EW      = CLK_MHZ * ENS / 1000;

  localparam logic [4:0] M_PROG  = 5'b10000;
  localparam logic [4:0] M_ERASE = 5'b01000;
  localparam logic [4:0] M_SUSP  = 5'b00100;
  localparam logic [4:0] M_RES   = 5'b00010;
  localparam logic [4:0] M_DONE  = 5'b00001;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_prog = 0, cmd_erase = 0, cmd_susp = 0, cmd_resume = 0;
  logic       tgt_prot = 0, op_done = 0, rd = 0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] rd_data;
  logic       rd_valid, busy_oe;
  logic       rb_line;

  int   n_chk = 0, n_fail = 0;
  logic exp_t6 = 1'b0;
  logic [7:0] arr_pat = 8'h5A;
  logic done_flag = 1'b0;

  flash_status_gen #(.CLK_MHZ(CLK_MHZ), .PROG_PROT_NS(PNS), .ERASE_PROT_NS(ENS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_prog_i(cmd_prog), .cmd_erase_i(cmd_erase),
    .cmd_susp_i(cmd_susp), .cmd_resume_i(cmd_resume), .tgt_prot_i(tgt_prot),
    .op_done_i(op_done), .rd_i(rd), .array_data_i(array_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .busy_oe_o(busy_oe)
  );

  // Board pull-up on the open-drain ready/busy line
  assign rb_line = busy_oe ? 1'b0 : 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] m, input logic prot);
    @(negedge clk);
    {cmd_prog, cmd_erase, cmd_susp, cmd_resume, op_done} = m;
    tgt_prot = prot;
    @(negedge clk);
    {cmd_prog, cmd_erase, cmd_susp, cmd_resume, op_done} = 5'b0;
    tgt_prot = 1'b0;
  endtask

  task automatic rb_chk(input string req, input logic busy_exp);
    chk(req, {31'b0, rb_line}, {31'b0, ~busy_exp});
  endtask

  task automatic rd_chk(input string req, input logic busy_exp);
    logic [7:0] e;
    @(negedge clk);
    arr_pat    = {arr_pat[6:0], arr_pat[7] ^ arr_pat[5]} + 8'd3;
    array_data = arr_pat;
    rd         = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    if (busy_exp) begin
      exp_t6 = ~exp_t6;
      e      = 8'h00;
      e[6]   = exp_t6;
    end else begin
      e = arr_pat;
    end
    chk(req, {24'b0, rd_data}, {24'b0, e});
    chk("R4", {31'b0, rd_valid}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rb_chk("R1", 1'b0);
    chk("R1", {31'b0, rd_valid}, 32'd0);
    rd_chk("R1", 1'b0);
    @(negedge clk);
    chk("R4", {31'b0, rd_valid}, 32'd0);

    // R2/R3/R5: sweep over read counts for program and erase
    for (int n = 1; n <= 6; n++) begin
      drive(M_PROG, 1'b0);
      rb_chk("R2", 1'b1);
      for (int k = 0; k < n; k++) rd_chk("R5", 1'b1);
      drive(M_DONE, 1'b0);
      rb_chk("R2", 1'b0);
      rd_chk("R6", 1'b0);

      drive(M_ERASE, 1'b0);
      rb_chk("R3", 1'b1);
      for (int k = 0; k < n + 1; k++) rd_chk("R5", 1'b1);
      drive(M_DONE, 1'b0);
      rb_chk("R3", 1'b0);
      rd_chk("R6", 1'b0);
    end

    // R3: program wins over erase in idle
    drive(M_PROG | M_ERASE, 1'b0);
    drive(M_SUSP, 1'b0);
    rb_chk("R3", 1'b1);   // suspend would have released an erase
    drive(M_DONE, 1'b0);
    rb_chk("R3", 1'b0);

    // R11: ignored commands during program and in idle
    drive(M_PROG, 1'b0);
    drive(M_ERASE, 1'b0);
    drive(M_SUSP, 1'b0);
    drive(M_RES, 1'b0);
    drive(M_PROG, 1'b0);
    rb_chk("R11", 1'b1);
    rd_chk("R11", 1'b1);
    drive(M_DONE, 1'b0);
    rb_chk("R11", 1'b0);
    drive(M_DONE, 1'b0);
    drive(M_RES, 1'b0);
    rb_chk("R11", 1'b0);
    rd_chk("R11", 1'b0);

    // R7: suspend freezes bit 6, resume continues from held value
    for (int m = 0; m < 3; m++) begin
      drive(M_ERASE, 1'b0);
      rd_chk("R7", 1'b1);
      drive(M_SUSP, 1'b0);
      rb_chk("R7", 1'b0);
      for (int k = 0; k <= m; k++) rd_chk("R7", 1'b0);
      drive(M_RES, 1'b0);
      rb_chk("R7", 1'b1);
      rd_chk("R7", 1'b1);
      drive(M_DONE, 1'b0);
      rb_chk("R7", 1'b0);
    end

    // R8: program during erase suspend
    drive(M_ERASE, 1'b0);
    drive(M_SUSP, 1'b0);
    drive(M_PROG, 1'b0);
    rb_chk("R8", 1'b1);
    rd_chk("R8", 1'b1);
    rd_chk("R8", 1'b1);
    rd_chk("R8", 1'b1);
    drive(M_DONE, 1'b0);
    rb_chk("R8", 1'b0);
    rd_chk("R8", 1'b0);
    drive(M_RES, 1'b0);       // back in suspend, so resume restores erase
    rb_chk("R8", 1'b1);
    drive(M_DONE, 1'b0);
    rb_chk("R8", 1'b0);

    // R9: protected program window length, counted cycle by cycle
    drive(M_PROG, 1'b1);
    for (int k = 0; k < PW; k++) begin
      rb_chk("R9", 1'b1);
      @(negedge clk);
    end
    rb_chk("R9", 1'b0);
    rd_chk("R9", 1'b0);

    // R9: toggles and ignores done inside the window
    drive(M_PROG, 1'b1);
    rd_chk("R9", 1'b1);
    repeat (PW) @(negedge clk);
    rb_chk("R9", 1'b0);
    drive(M_PROG, 1'b1);
    drive(M_DONE, 1'b0);
    rb_chk("R9", 1'b1);
    repeat (PW) @(negedge clk);
    rb_chk("R9", 1'b0);

    // R9: protected program from erase suspend returns to suspend
    drive(M_ERASE, 1'b0);
    rd_chk("R9", 1'b1);
    drive(M_SUSP, 1'b0);
    drive(M_PROG, 1'b1);
    for (int k = 0; k < PW; k++) begin
      rb_chk("R9", 1'b1);
      @(negedge clk);
    end
    rb_chk("R9", 1'b0);
    rd_chk("R9", 1'b0);
    drive(M_RES, 1'b0);
    rb_chk("R9", 1'b1);
    rd_chk("R9", 1'b1);
    drive(M_DONE, 1'b0);
    rb_chk("R9", 1'b0);

    // R10: protected erase window length
    drive(M_ERASE, 1'b1);
    for (int k = 0; k < EW; k++) begin
      rb_chk("R10", 1'b1);
      @(negedge clk);
    end
    rb_chk("R10", 1'b0);
    drive(M_ERASE, 1'b1);
    rd_chk("R10", 1'b1);
    rd_chk("R10", 1'b1);
    repeat (EW) @(negedge clk);
    rb_chk("R10", 1'b0);
    rd_chk("R10", 1'b0);

    // R12: done and suspend together during erase
    drive(M_ERASE, 1'b0);
    drive(M_DONE | M_SUSP, 1'b0);
    rb_chk("R12", 1'b0);
    drive(M_RES, 1'b0);       // idle ignores resume; a suspend state would not
    rb_chk("R12", 1'b0);

    done_flag = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule